// File: doc/BRIEF.md
# 5b/4b Line Receiver with Command Framing

This block sits at the front of a serial cell receiver. It takes one NRZI-coded line bit per enabled clock, recovers the raw bit stream, and finds symbol boundaries by searching for the escape code. Once aligned, it cuts the stream into 5-bit symbols and maps each one to a 4-bit nibble or to escape. Invalid codes are flagged and never corrected.

After alignment, every received symbol leaves the block as one nibble strobe, tagged as a command or a data nibble. A downstream descrambler can therefore advance its generator once per symbol and stay in step. The block reads escape pairs as commands. One pair is a timing marker. Two other pairs are start-of-cell commands, and after one of those the block frames a cell of a fixed number of bytes. Each cell byte is built from two data nibbles. The escape-escape form also asks the descrambler to reload its generator.

Top module: `rx_sym_decoder`

## Requirements
- R1: A decoded bit is 1 when the sampled `line_in` level differs from the level sampled at the previous enabled clock, and 0 otherwise. The reference level is 0 after reset.
- R2: Symbols arrive most significant bit first. Escape is 00010. A nibble d with d[1:0] != 00 has the symbol {d[3],1,d[2],d[1:0]}. Nibble 0 is 10101, 4 is 00111, 8 is 10010 and C is 10111. The other 15 codes are invalid.
- R3: Out of reset the block is unaligned. `locked` is 0 and no nibble strobe is given. Alignment is taken when the last five bits equal escape, and from then on a symbol ends every fifth bit.
- R4: LOSS_LIMIT (default 4) consecutive invalid symbols clear `locked`. Fewer than that, followed by a valid one, keep it set.
- R5: While aligned, each symbol gives exactly one `nib_valid` pulse. `nib_cmd` is 1 for both symbols of an escape pair and 0 for every other symbol.
- R6: Escape followed by nibble 8 pulses `timing_marker`. It may appear anywhere, including inside a cell, and does not change the cell's bytes.
- R7: Escape followed by escape, or by nibble 4, starts a cell. The next CELL_BYTES (default 53) bytes are delivered on `byte_out`. Each byte takes its first data nibble as bits 7:4 and its second as bits 3:0.
- R8: `start_of_cell` is 1 together with the first byte of a cell and never with any other byte.
- R9: `scr_reload` pulses for an escape-escape command, on the second escape's nibble strobe. It does not pulse for escape followed by 4.
- R10: An invalid symbol pulses `symbol_error`. Inside a cell it still fills its nibble slot, with value 0, so the byte count is not disturbed.
- R11: Escape followed by any data nibble other than 4 or 8 pulses `cmd_error` and starts no cell.
- R12: A start-of-cell command received during a cell restarts the byte count at byte 1.
- R13: Clocks with `line_en` low are ignored by the decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | NRZI line level |
| line_en | input | 1 | Qualifies `line_in` as a new bit |
| locked | output | 1 | Symbol alignment held |
| nib_valid | output | 1 | One pulse per aligned symbol |
| nib_out | output | 4 | Decoded nibble (0 for escape or invalid) |
| nib_cmd | output | 1 | Current nibble belongs to an escape pair |
| scr_reload | output | 1 | Descrambler reload request |
| byte_valid | output | 1 | `byte_out` holds a cell byte |
| byte_out | output | 8 | Cell byte |
| start_of_cell | output | 1 | Marks byte 1 of a cell |
| timing_marker | output | 1 | Timing marker received |
| symbol_error | output | 1 | Invalid symbol received |
| cmd_error | output | 1 | Escape followed by an unknown nibble |

## Verification
The hardest situations to reach are an escape pair arriving between the two nibbles of a cell byte, and the loss of alignment after a run of bad codes. The bench has its own NRZI and 5b encoder, so it can place a timing marker between the high and low nibble of a chosen byte, and replace any single nibble with an unused code. It drives a run of exactly LOSS_LIMIT-1 bad codes followed by a valid one, then a full run of LOSS_LIMIT. After that it checks that nothing is emitted until a fresh escape restores alignment. The bench also stretches every bit with idle enable gaps.

// File: rtl/rx_sym_pkg.sv
package rx_sym_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;
  localparam logic [SYM_W-1:0] ESC_CODE = 5'b00010;
  localparam logic [NIB_W-1:0] CMD_MARK = 4'h8;
  localparam logic [NIB_W-1:0] CMD_SOC  = 4'h4;

  // Nibble to line symbol; the decoder searches this mapping.
  function automatic logic [SYM_W-1:0] nib_to_sym(input logic [NIB_W-1:0] d);
    logic [SYM_W-1:0] s;
    if (d[1:0] != 2'b00) begin
      s = {d[3], 1'b1, d[2], d[1:0]};
    end else begin
      case (d[3:2])
        2'd0:    s = 5'b10101;
        2'd1:    s = 5'b00111;
        2'd2:    s = 5'b10010;
        default: s = 5'b10111;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/nrzi_rx.sv
module nrzi_rx (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic line_en,
  output logic bit_out,
  output logic bit_vld
);
  logic prev_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      bit_out  <= 1'b0;
      bit_vld  <= 1'b0;
    end else begin
      bit_vld <= line_en;
      if (line_en) begin
        bit_out  <= line_in ^ prev_lvl;
        prev_lvl <= line_in;
      end
    end
  end

  // R13
  en_gives_bit_chk: assert property (@(posedge clk) disable iff (rst)
    line_en |=> bit_vld);
  // R13
  no_en_no_bit_chk: assert property (@(posedge clk) disable iff (rst)
    !line_en |=> !bit_vld);
endmodule

// File: rtl/sym_lookup.sv
module sym_lookup
  import rx_sym_pkg::*;
(
  input  logic [SYM_W-1:0] code,
  output logic [NIB_W-1:0] nib,
  output logic             is_esc,
  output logic             valid_symbol
);
  always_comb begin
    nib          = '0;
    is_esc       = (code == ESC_CODE);
    valid_symbol = is_esc;
    for (int i = 0; i < (1 << NIB_W); i++) begin
      if (nib_to_sym(i[NIB_W-1:0]) == code) begin
        nib          = i[NIB_W-1:0];
        valid_symbol = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sym_aligner.sv
module sym_aligner
  import rx_sym_pkg::*;
#(
  parameter int LOSS_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_vld,
  output logic             locked,
  output logic             sym_vld,
  output logic             sym_ok,
  output logic             sym_esc,
  output logic [NIB_W-1:0] sym_nib
);
  localparam int PH_W  = $clog2(SYM_W);
  localparam int RUN_W = $clog2(LOSS_LIMIT + 1);

  logic [SYM_W-1:0] shreg, shreg_n;
  logic [PH_W-1:0]  phase;
  logic [RUN_W-1:0] bad_run;
  logic [NIB_W-1:0] lk_nib;
  logic             lk_esc, lk_ok;

  assign shreg_n = {shreg[SYM_W-2:0], bit_in};

  sym_lookup u_lookup (
    .code        (shreg_n),
    .nib         (lk_nib),
    .is_esc      (lk_esc),
    .valid_symbol(lk_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      phase   <= '0;
      bad_run <= '0;
      locked  <= 1'b0;
      sym_vld <= 1'b0;
      sym_ok  <= 1'b0;
      sym_esc <= 1'b0;
      sym_nib <= '0;
    end else begin
      sym_vld <= 1'b0;
      if (bit_vld) begin
        shreg <= shreg_n;
        if (!locked) begin
          if (lk_esc) begin
            locked  <= 1'b1;
            phase   <= '0;
            bad_run <= '0;
            sym_vld <= 1'b1;
            sym_ok  <= 1'b1;
            sym_esc <= 1'b1;
            sym_nib <= lk_nib;
          end
        end else if (phase == PH_W'(SYM_W - 1)) begin
          phase   <= '0;
          sym_vld <= 1'b1;
          sym_ok  <= lk_ok;
          sym_esc <= lk_esc;
          sym_nib <= lk_nib;
          if (!lk_ok) begin
            if (bad_run == RUN_W'(LOSS_LIMIT - 1)) begin
              locked  <= 1'b0;
              bad_run <= '0;
            end else begin
              bad_run <= bad_run + 1'b1;
            end
          end else begin
            bad_run <= '0;
          end
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  // R3
  lock_on_escape_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (sym_vld && sym_esc));
  // R4
  unlock_on_bad_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> (sym_vld && !sym_ok));
endmodule

// File: rtl/cell_framer.sv
module cell_framer
  import rx_sym_pkg::*;
#(
  parameter int CELL_BYTES = 53
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             locked,
  input  logic             sym_vld,
  input  logic             sym_ok,
  input  logic             sym_esc,
  input  logic [NIB_W-1:0] sym_nib,
  output logic             nib_valid,
  output logic [NIB_W-1:0] nib_out,
  output logic             nib_cmd,
  output logic             scr_reload,
  output logic             byte_valid,
  output logic [2*NIB_W-1:0] byte_out,
  output logic             start_of_cell,
  output logic             timing_marker,
  output logic             symbol_error,
  output logic             cmd_error
);
  localparam int NIBS  = 2 * CELL_BYTES;
  localparam int CNT_W = $clog2(NIBS);
  localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(NIBS - 1);

  logic             esc_pend, in_cell;
  logic [CNT_W-1:0] nib_cnt;
  logic [NIB_W-1:0] hi_nib;
  logic             is_esc_now, take_data;
  logic [NIB_W-1:0] data_nib;

  always_comb begin
    is_esc_now = sym_ok && sym_esc;
    take_data  = locked && sym_vld && in_cell && !esc_pend && !is_esc_now;
    data_nib   = sym_ok ? sym_nib : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      esc_pend      <= 1'b0;
      in_cell       <= 1'b0;
      nib_cnt       <= '0;
      hi_nib        <= '0;
      nib_valid     <= 1'b0;
      nib_out       <= '0;
      nib_cmd       <= 1'b0;
      scr_reload    <= 1'b0;
      byte_valid    <= 1'b0;
      byte_out      <= '0;
      start_of_cell <= 1'b0;
      timing_marker <= 1'b0;
      symbol_error  <= 1'b0;
      cmd_error     <= 1'b0;
    end else begin
      nib_valid     <= 1'b0;
      nib_cmd       <= 1'b0;
      scr_reload    <= 1'b0;
      byte_valid    <= 1'b0;
      start_of_cell <= 1'b0;
      timing_marker <= 1'b0;
      symbol_error  <= 1'b0;
      cmd_error     <= 1'b0;
      if (!locked) begin
        esc_pend <= 1'b0;
        in_cell  <= 1'b0;
        nib_cnt  <= '0;
      end else if (sym_vld) begin
        nib_valid    <= 1'b1;
        nib_out      <= (sym_ok && !sym_esc) ? sym_nib : '0;
        nib_cmd      <= esc_pend || is_esc_now;
        symbol_error <= !sym_ok;
        if (esc_pend) begin
          esc_pend <= 1'b0;
          if (sym_ok) begin
            if (sym_esc || sym_nib == CMD_SOC) begin
              in_cell    <= 1'b1;
              nib_cnt    <= '0;
              scr_reload <= sym_esc;
            end else if (sym_nib == CMD_MARK) begin
              timing_marker <= 1'b1;
            end else begin
              cmd_error <= 1'b1;
            end
          end
        end else if (is_esc_now) begin
          esc_pend <= 1'b1;
        end else if (take_data) begin
          if (!nib_cnt[0]) begin
            hi_nib <= data_nib;
          end else begin
            byte_valid    <= 1'b1;
            byte_out      <= {hi_nib, data_nib};
            start_of_cell <= (nib_cnt == CNT_W'(1));
          end
          if (nib_cnt == LAST_NIB) begin
            in_cell <= 1'b0;
            nib_cnt <= '0;
          end else begin
            nib_cnt <= nib_cnt + 1'b1;
          end
        end
      end
    end
  end

  // R8
  soc_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
    start_of_cell |-> byte_valid);
  // R6
  event_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({timing_marker, byte_valid, cmd_error, scr_reload}));
  // R9
  reload_is_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    scr_reload |-> (nib_valid && nib_cmd));
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    nib_cnt <= LAST_NIB);
  // R5
  nib_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    nib_valid |-> $past(locked));
endmodule

// File: rtl/rx_sym_decoder.sv
module rx_sym_decoder
  import rx_sym_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int LOSS_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_in,
  input  logic       line_en,
  output logic       locked,
  output logic       nib_valid,
  output logic [3:0] nib_out,
  output logic       nib_cmd,
  output logic       scr_reload,
  output logic       byte_valid,
  output logic [7:0] byte_out,
  output logic       start_of_cell,
  output logic       timing_marker,
  output logic       symbol_error,
  output logic       cmd_error
);
  logic             raw_bit, raw_vld;
  logic             sym_vld, sym_ok, sym_esc;
  logic [NIB_W-1:0] sym_nib;

  nrzi_rx u_nrzi (
    .clk    (clk),
    .rst    (rst),
    .line_in(line_in),
    .line_en(line_en),
    .bit_out(raw_bit),
    .bit_vld(raw_vld)
  );

  sym_aligner #(.LOSS_LIMIT(LOSS_LIMIT)) u_align (
    .clk    (clk),
    .rst    (rst),
    .bit_in (raw_bit),
    .bit_vld(raw_vld),
    .locked (locked),
    .sym_vld(sym_vld),
    .sym_ok (sym_ok),
    .sym_esc(sym_esc),
    .sym_nib(sym_nib)
  );

  cell_framer #(.CELL_BYTES(CELL_BYTES)) u_framer (
    .clk          (clk),
    .rst          (rst),
    .locked       (locked),
    .sym_vld      (sym_vld),
    .sym_ok       (sym_ok),
    .sym_esc      (sym_esc),
    .sym_nib      (sym_nib),
    .nib_valid    (nib_valid),
    .nib_out      (nib_out),
    .nib_cmd      (nib_cmd),
    .scr_reload   (scr_reload),
    .byte_valid   (byte_valid),
    .byte_out     (byte_out),
    .start_of_cell(start_of_cell),
    .timing_marker(timing_marker),
    .symbol_error (symbol_error),
    .cmd_error    (cmd_error)
  );
endmodule

// File: tb/rx_sym_decoder_bench.sv
module rx_sym_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 53;
  localparam int LOSS       = 4;
  localparam logic [4:0] ESC = 5'b00010;
  localparam logic [4:0] BAD = 5'b00000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_in = 1'b0;
  logic line_en = 1'b0;
  logic locked, nib_valid, nib_cmd, scr_reload, byte_valid;
  logic start_of_cell, timing_marker, symbol_error, cmd_error;
  logic [3:0] nib_out;
  logic [7:0] byte_out;

  rx_sym_decoder #(.CELL_BYTES(NBYTES), .LOSS_LIMIT(LOSS)) u_rx_sym_decoder (
    .clk(clk), .rst(rst), .line_in(line_in), .line_en(line_en),
    .locked(locked), .nib_valid(nib_valid), .nib_out(nib_out),
    .nib_cmd(nib_cmd), .scr_reload(scr_reload), .byte_valid(byte_valid),
    .byte_out(byte_out), .start_of_cell(start_of_cell),
    .timing_marker(timing_marker), .symbol_error(symbol_error),
    .cmd_error(cmd_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  logic lvl = 1'b0;

  int n_nib, n_cmd, n_soc, soc_pos, n_tm, n_rel, n_serr, n_cerr;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];

  always @(negedge clk) begin
    if (!rst) begin
      if (nib_valid) n_nib++;
      if (nib_valid && nib_cmd) n_cmd++;
      if (timing_marker) n_tm++;
      if (scr_reload) n_rel++;
      if (symbol_error) n_serr++;
      if (cmd_error) n_cerr++;
      if (byte_valid) begin
        got_q.push_back(byte_out);
        if (start_of_cell) begin
          n_soc++;
          soc_pos = got_q.size() - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_nib = 0; n_cmd = 0; n_soc = 0; soc_pos = -1; n_tm = 0;
    n_rel = 0; n_serr = 0; n_cerr = 0;
    got_q.delete();
    exp_q.delete();
  endtask

  function automatic logic [4:0] enc(input logic [3:0] d);
    case (d)
      4'h0: return 5'b10101;  4'h1: return 5'b01001;
      4'h2: return 5'b01010;  4'h3: return 5'b01011;
      4'h4: return 5'b00111;  4'h5: return 5'b01101;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b11001;
      4'hA: return 5'b11010;  4'hB: return 5'b11011;
      4'hC: return 5'b10111;  4'hD: return 5'b11101;
      4'hE: return 5'b11110;  default: return 5'b11111;
    endcase
  endfunction

  task automatic send_bit(input logic b, input bit gaps);
    @(negedge clk);
    lvl = lvl ^ b;
    line_in = lvl;
    line_en = 1'b1;
    if (gaps) begin
      @(negedge clk);
      line_en = 1'b0;
      line_in = ~lvl;
    end
  endtask

  task automatic send_sym(input logic [4:0] s, input bit gaps);
    for (int k = 4; k >= 0; k--) send_bit(s[k], gaps);
  endtask

  task automatic flush();
    @(negedge clk);
    line_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_cell(input bit use_x4, input int seed, input int nb,
                           input int mark_at, input int err_at, input bit gaps);
    send_sym(ESC, gaps);
    send_sym(use_x4 ? enc(4'h4) : ESC, gaps);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b;
      b = 8'(seed + i * 37);
      send_sym(enc(b[7:4]), gaps);
      if (i == mark_at) begin
        send_sym(ESC, gaps);
        send_sym(enc(4'h8), gaps);
      end
      if (i == err_at) begin
        send_sym(BAD, gaps);
        exp_q.push_back({b[7:4], 4'h0});
      end else begin
        send_sym(enc(b[3:0]), gaps);
        exp_q.push_back(b);
      end
    end
  endtask

  task automatic cmp_bytes(input string tag);
    int bad = 0;
    chk(got_q.size() == exp_q.size(), {tag, " byte count"}, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size()) begin
      for (int i = 0; i < exp_q.size(); i++) begin
        if (got_q[i] !== exp_q[i] && bad == 0) begin
          bad = 1;
          chk(1'b0, {tag, " byte value"}, got_q[i], exp_q[i]);
        end
      end
      if (bad == 0) chk(1'b1, tag, 0, 0);
    end
  endtask

  task automatic t_reset();
    chk(locked == 1'b0, "R3 locked after reset", locked, 0);
    chk({nib_valid, byte_valid, start_of_cell, timing_marker, scr_reload,
         symbol_error, cmd_error} == 7'b0, "R5 outputs idle after reset",
        {nib_valid, byte_valid, start_of_cell, timing_marker}, 0);
  endtask

  task automatic t_unlocked();
    clear_mon();
    for (int i = 0; i < 6; i++) send_sym(enc(4'hF), 1'b0);
    flush();
    chk(n_nib == 0, "R3 no nibbles before alignment", n_nib, 0);
    chk(locked == 1'b0, "R3 still unaligned", locked, 0);
  endtask

  task automatic t_cell_xx();
    clear_mon();
    send_cell(1'b0, 3, NBYTES, -1, -1, 1'b0);
    for (int i = 0; i < 3; i++) send_sym(enc(4'hF), 1'b0);
    flush();
    chk(locked == 1'b1, "R3 aligned on escape", locked, 1);
    cmp_bytes("R1 R2 R7 cell after escape pair");
    chk(n_soc == 1 && soc_pos == 0, "R8 start on byte 1", soc_pos, 0);
    chk(n_rel == 1, "R9 reload on escape pair", n_rel, 1);
    chk(n_nib == 2 + 2*NBYTES + 3, "R5 one strobe per symbol", n_nib, 2 + 2*NBYTES + 3);
    chk(n_cmd == 2, "R5 command tags", n_cmd, 2);
  endtask

  task automatic t_cell_x4();
    clear_mon();
    send_cell(1'b1, 91, NBYTES, -1, -1, 1'b0);
    send_sym(enc(4'hF), 1'b0);
    flush();
    cmp_bytes("R7 cell after escape-4");
    chk(n_rel == 0, "R9 no reload for escape-4", n_rel, 0);
    chk(n_soc == 1 && soc_pos == 0, "R8 start with escape-4", soc_pos, 0);
  endtask

  task automatic t_marker();
    clear_mon();
    send_sym(ESC, 1'b0);
    send_sym(enc(4'h8), 1'b0);
    send_sym(enc(4'hF), 1'b0);
    flush();
    chk(n_tm == 1 && got_q.size() == 0, "R6 idle marker", n_tm, 1);
    clear_mon();
    send_cell(1'b0, 17, NBYTES, 10, -1, 1'b0);
    send_sym(enc(4'hF), 1'b0);
    flush();
    chk(n_tm == 1, "R6 marker inside cell", n_tm, 1);
    cmp_bytes("R6 cell with marker mid-byte");
    chk(n_cmd == 4, "R5 marker tagged as command", n_cmd, 4);
  endtask

  task automatic t_symerr();
    clear_mon();
    send_cell(1'b1, 200, NBYTES, -1, 20, 1'b0);
    send_sym(enc(4'hF), 1'b0);
    flush();
    chk(n_serr == 1, "R10 error flagged", n_serr, 1);
    cmp_bytes("R10 slot kept with zero nibble");
  endtask

  task automatic t_cmderr();
    clear_mon();
    send_sym(ESC, 1'b0);
    send_sym(enc(4'h5), 1'b0);
    for (int i = 0; i < 4; i++) send_sym(enc(4'h3), 1'b0);
    flush();
    chk(n_cerr == 1, "R11 unknown command", n_cerr, 1);
    chk(n_soc == 0 && got_q.size() == 0, "R11 no cell started", got_q.size(), 0);
  endtask

  task automatic t_restart();
    clear_mon();
    send_cell(1'b0, 5, 10, -1, -1, 1'b0);
    send_cell(1'b0, 60, NBYTES, -1, -1, 1'b0);
    send_sym(enc(4'hF), 1'b0);
    flush();
    cmp_bytes("R12 restarted cell");
    chk(n_soc == 2 && soc_pos == 10, "R12 second start at byte 1", soc_pos, 10);
  endtask

  task automatic t_stall();
    clear_mon();
    send_cell(1'b1, 133, NBYTES, -1, -1, 1'b1);
    send_sym(enc(4'hF), 1'b1);
    flush();
    cmp_bytes("R13 cell with enable gaps");
  endtask

  task automatic t_lockloss();
    clear_mon();
    for (int i = 0; i < LOSS - 1; i++) send_sym(BAD, 1'b0);
    send_sym(enc(4'hF), 1'b0);
    flush();
    chk(locked == 1'b1, "R4 short bad run keeps lock", locked, 1);
    for (int i = 0; i < LOSS; i++) send_sym(BAD, 1'b0);
    flush();
    chk(locked == 1'b0, "R4 lock dropped", locked, 0);
    clear_mon();
    for (int i = 0; i < 3; i++) send_sym(enc(4'hF), 1'b0);
    flush();
    chk(n_nib == 0, "R4 silent after loss", n_nib, 0);
    clear_mon();
    send_cell(1'b0, 77, NBYTES, -1, -1, 1'b0);
    send_sym(enc(4'hF), 1'b0);
    flush();
    cmp_bytes("R3 realigned cell");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unlocked();
    t_cell_xx();
    t_cell_x4();
    t_marker();
    t_symerr();
    t_cmderr();
    t_restart();
    t_stall();
    t_lockloss();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule